// File: doc/BRIEF.md
# OTG Comparator Status and Interrupt Register Block

This block gives software a view of the OTG line comparators. It synchronises the comparator inputs and shows each one as a live status bit. Any change of a comparator input is caught in a sticky change flag. Each flag has its own enable, and the enabled flags are combined into one interrupt line. The block also runs a millisecond toggle from a prescaled timebase, and that toggle counts as one more source. A small control field drives the VBUS charge and discharge requests, the OTG termination and the data-pulse driver.

A second word is the command register. It holds the run/stop bit and a controller-reset bit. The reset bit starts a soft reset. While the reset runs, the bit reads as 1 and the block ignores all writes. When it ends, the bit clears itself and every writable field is back at its default. Software reaches both words through a single-cycle port: a write takes effect at the clock edge where it is sampled, and read data is registered and valid after the next edge.

Top module: `otg_event_csr`

## Requirements
- R1: After the hardware reset, the command word (address 0) reads 0. With all sense inputs low, the status word (address 1) reads 0, except bit 13 and bit 21, which follow the timebase. irq_o, run_o and all control outputs are 0.
- R2: Status word bits 8 to 14 show the synchronised sources in this order: line_det[0] at 8, line_det[1] at 9, line_det[2] at 10, line_det[3] at 11, line_det[4] at 12, the millisecond toggle at 13, pulse_det at 14. Bits 2, 5 to 7, 15, 23 and 31 always read 0.
- R3: A rising or a falling edge of source k sets flag bit 16+k, and the flag stays set until it is cleared.
- R4: Writing the status word with a 1 in flag bit 16+k clears that flag, and a 0 leaves it unchanged. So writing back the value just read acknowledges every pending flag.
- R5: If a new edge of a source and a write-one-to-clear of its flag fall in the same cycle, the flag ends up set.
- R6: Enable bits 24 to 30 can be read and written, one per source in the same order. irq_o is the registered OR of (flag AND enable), so a flag whose enable is 0 never raises irq_o.
- R7: Status word bits 0, 1, 3 and 4 can be read and written. They drive vbus_dischg_o, vbus_chg_o, term_o and pulse_drv_o respectively.
- R8: The toggle at bit 13 inverts once every TICK_CYCLES clocks, and each inversion sets flag bit 21.
- R9: Command bit 0 is run/stop. It can be read and written, and it drives run_o. Other command bits written as 0 have no effect.
- R10: Writing 1 to command bit 1 starts a soft reset. Bit 1 reads 1 for exactly RST_CYCLES cycles and then reads 0. The soft reset clears run, control, flags, enables and the toggle; the enables then read 0.
- R11: While a soft reset is running, writes to either word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address (0 command, 1 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read |
| line_det | input | 5 | Asynchronous comparator inputs (sources 0 to 4) |
| pulse_det | input | 1 | Asynchronous data-pulse detect (source 6) |
| vbus_dischg_o | output | 1 | VBUS discharge request |
| vbus_chg_o | output | 1 | VBUS charge request |
| term_o | output | 1 | OTG termination enable |
| pulse_drv_o | output | 1 | Data-pulse drive request |
| run_o | output | 1 | Run/stop state |
| irq_o | output | 1 | Interrupt request |

## Verification
A software acknowledge and a new edge of the same source can arrive in the same cycle. The clear must then lose to the set, or an event would be lost. The bench provokes this case by changing one comparator input at a known clock phase. It then times a write-one-to-clear of that source's flag so that the write is sampled at the very edge where the synchronised change sets the flag. The case passes if a read afterwards still shows the flag set, and if a second, lone acknowledge then clears it.

// File: rtl/otg_csr_pkg.sv
package otg_csr_pkg;

  localparam int unsigned SRC_N    = 7;   // total interrupt sources
  localparam int unsigned EXT_N    = 6;   // sources arriving from pins
  localparam int unsigned SRC_TICK = 5;   // slot of the millisecond toggle
  localparam int unsigned LIVE_LSB = 8;
  localparam int unsigned FLAG_LSB = 16;
  localparam int unsigned EN_LSB   = 24;
  localparam int unsigned CTL_W    = 5;
  localparam logic [CTL_W-1:0] CTL_RW_MASK = 5'b11011;
  localparam int unsigned CMD_RUN_BIT = 0;
  localparam int unsigned CMD_RST_BIT = 1;

  // place the internal toggle between the line sources and pulse detect
  function automatic logic [SRC_N-1:0] merge_src(input logic [EXT_N-1:0] ext,
                                                 input logic tick);
    return {ext[EXT_N-1], tick, ext[EXT_N-2:0]};
  endfunction

  function automatic logic [31:0] pack_status(input logic [CTL_W-1:0] ctl,
                                              input logic [SRC_N-1:0] live,
                                              input logic [SRC_N-1:0] flags,
                                              input logic [SRC_N-1:0] en);
    logic [31:0] w;
    w = '0;
    w[CTL_W-1:0]           = ctl & CTL_RW_MASK;
    w[LIVE_LSB +: SRC_N]   = live;
    w[FLAG_LSB +: SRC_N]   = flags;
    w[EN_LSB +: SRC_N]     = en;
    return w;
  endfunction

endpackage

// File: rtl/otg_sense_sync.sv
module otg_sense_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] change_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= STAGES'({chain, raw_i[i]});
        prev  <= chain[STAGES-1];
      end
    end

    assign level_o[i]  = chain[STAGES-1];
    assign change_o[i] = chain[STAGES-1] ^ prev;
  end

endmodule

// File: rtl/otg_ms_timebase.sv
module otg_ms_timebase #(
  parameter int unsigned TICK_CYCLES = 48000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic toggle_o,
  output logic flip_o
);

  localparam int unsigned CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic             wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      tog <= ~tog;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign toggle_o = tog;
  assign flip_o   = wrap & ~clr_i;

endmodule

// File: rtl/otg_soft_reset.sv
module otg_soft_reset #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic clr_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_i && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(HOLD_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign busy_o = busy;
  assign clr_o  = busy | start_i;

endmodule

// File: rtl/otg_irq_flags.sv
module otg_irq_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);

  logic [N-1:0] flag_q;
  logic [N-1:0] en_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~w1c_i) | set_i;   // set has priority
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_q & en_q);
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/otg_event_csr.sv
module otg_event_csr
  import otg_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_CYCLES = 48000,
  parameter int unsigned RST_CYCLES  = 16,
  parameter int unsigned CMD_ADDR    = 0,
  parameter int unsigned OTG_ADDR    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [4:0]        line_det,
  input  logic              pulse_det,
  output logic              vbus_dischg_o,
  output logic              vbus_chg_o,
  output logic              term_o,
  output logic              pulse_drv_o,
  output logic              run_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] A_OTG = ADDR_W'(OTG_ADDR);

  logic [EXT_N-1:0] ext_level, ext_change;
  logic             tick_tog, tick_flip;
  logic [SRC_N-1:0] live_vec, edge_vec, w1c_vec, flag_vec, en_vec;
  logic             soft_busy, soft_clr, soft_start;
  logic             wr_ok, hit_cmd, hit_otg;
  logic [CTL_W-1:0] ctl_q;
  logic             run_q;
  logic [31:0]      rdata_q;
  logic             unused_wdata;

  assign hit_cmd    = (bus_addr == A_CMD);
  assign hit_otg    = (bus_addr == A_OTG);
  assign wr_ok      = bus_sel & bus_wr & ~soft_busy;
  assign soft_start = wr_ok & hit_cmd & bus_wdata[CMD_RST_BIT];
  assign w1c_vec    = (wr_ok && hit_otg) ? bus_wdata[FLAG_LSB +: SRC_N] : '0;
  assign unused_wdata = ^{bus_wdata[31], bus_wdata[23], bus_wdata[15:5]};

  otg_sense_sync #(.WIDTH(EXT_N), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .raw_i    ({pulse_det, line_det}),
    .level_o  (ext_level),
    .change_o (ext_change)
  );

  otg_ms_timebase #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (soft_clr),
    .toggle_o (tick_tog),
    .flip_o   (tick_flip)
  );

  otg_soft_reset #(.HOLD_CYCLES(RST_CYCLES)) sreset_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (soft_start),
    .busy_o  (soft_busy),
    .clr_o   (soft_clr)
  );

  assign live_vec = merge_src(ext_level, tick_tog);
  assign edge_vec = merge_src(ext_change, tick_flip);

  otg_irq_flags #(.N(SRC_N)) flags_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (soft_clr),
    .set_i      (edge_vec),
    .w1c_i      (w1c_vec),
    .en_we_i    (wr_ok & hit_otg),
    .en_wdata_i (bus_wdata[EN_LSB +: SRC_N]),
    .flag_o     (flag_vec),
    .en_o       (en_vec),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      ctl_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (wr_ok && hit_otg) ctl_q <= bus_wdata[CTL_W-1:0] & CTL_RW_MASK;
      if (wr_ok && hit_cmd) run_q <= bus_wdata[CMD_RUN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_sel && !bus_wr) begin
      if (hit_cmd)      rdata_q <= {30'b0, soft_busy, run_q};
      else if (hit_otg) rdata_q <= pack_status(ctl_q, live_vec, flag_vec, en_vec);
      else              rdata_q <= '0;
    end
  end

  assign bus_rdata     = rdata_q;
  assign vbus_dischg_o = ctl_q[0];
  assign vbus_chg_o    = ctl_q[1];
  assign term_o        = ctl_q[3];
  assign pulse_drv_o   = ctl_q[4];
  assign run_o         = run_q;

endmodule

// File: rtl/otg_event_csr_chk.sv
module otg_event_csr_chk
  import otg_csr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [SRC_N-1:0] flag_vec,
  input logic [SRC_N-1:0] en_vec,
  input logic [SRC_N-1:0] edge_vec,
  input logic [SRC_N-1:0] w1c_vec,
  input logic             soft_clr,
  input logic             soft_busy,
  input logic             run_q,
  input logic             irq_o
);

  // R3: a detected edge leaves its flag set on the next cycle
  assert_edge_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    ((edge_vec != '0) && !soft_clr) |=> ((flag_vec & $past(edge_vec)) == $past(edge_vec)));

  // R5: an edge wins over a same-cycle acknowledge
  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (((edge_vec & w1c_vec) != '0) && !soft_clr)
      |=> ((flag_vec & $past(edge_vec & w1c_vec)) == $past(edge_vec & w1c_vec)));

  // R4: a flag only drops after a write-one-to-clear or a soft reset
  assert_flag_drop_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (((~flag_vec & $past(flag_vec) & ~$past(w1c_vec)) == '0) || $past(soft_clr)));

  // R6: masked flags keep the interrupt low
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    ((flag_vec & en_vec) == '0) |=> !irq_o);

  // R6: an enabled pending flag raises the interrupt
  assert_irq_raised_R6: assert property (@(posedge clk) disable iff (rst)
    ((flag_vec & en_vec) != '0) |=> irq_o);

  // R10: while the soft reset runs every field sits at its default
  assert_soft_reset_defaults_R10: assert property (@(posedge clk) disable iff (rst)
    soft_busy |-> ((flag_vec == '0) && (en_vec == '0) && !run_q));

endmodule

bind otg_event_csr otg_event_csr_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .flag_vec  (flag_vec),
  .en_vec    (en_vec),
  .edge_vec  (edge_vec),
  .w1c_vec   (w1c_vec),
  .soft_clr  (soft_clr),
  .soft_busy (soft_busy),
  .run_q     (run_q),
  .irq_o     (irq_o)
);

// File: tb/otg_event_csr_tb_top.sv
module otg_event_csr_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 16;
  localparam int RSTC       = 8;
  localparam logic [31:0] MSK = 32'hFFDF_DFFF;  // ignore toggle bit 13 and flag 21

  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SN = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] mask;
    logic [1:0]  irq;   // 0, 1, or 2 = not checked
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 2'd2, 4'd1},  // R1 command word
    '{OP_RD, 2'd1, 32'h0000_0000, MSK,           2'd0, 4'd1},  // R1 status word
    '{OP_SN, 2'd0, 32'h0000_0001, 32'h0,         2'd2, 4'd2},  // raise line 0
    '{OP_RD, 2'd1, 32'h0001_0100, MSK,           2'd2, 4'd2},  // R2 live bit 8, R3 flag 16
    '{OP_WR, 2'd1, 32'h0001_0000, 32'h0,         2'd2, 4'd4},  // R4 ack flag 16
    '{OP_RD, 2'd1, 32'h0000_0100, MSK,           2'd2, 4'd4},  // R4 cleared
    '{OP_SN, 2'd0, 32'h0000_0000, 32'h0,         2'd2, 4'd3},  // falling edge
    '{OP_RD, 2'd1, 32'h0001_0000, MSK,           2'd2, 4'd3},  // R3 falling sets flag
    '{OP_WR, 2'd1, 32'h0100_0000, 32'h0,         2'd2, 4'd6},  // R6 enable source 0
    '{OP_RD, 2'd1, 32'h0101_0000, MSK,           2'd1, 4'd6},  // R6 irq high
    '{OP_WR, 2'd1, 32'h0101_0000, 32'h0,         2'd2, 4'd4},  // R4 ack, keep enable
    '{OP_RD, 2'd1, 32'h0100_0000, MSK,           2'd0, 4'd6},  // R6 irq low again
    '{OP_SN, 2'd0, 32'h0000_0008, 32'h0,         2'd2, 4'd3},  // raise line 3
    '{OP_RD, 2'd1, 32'h0108_0800, MSK,           2'd0, 4'd6},  // R6 masked flag 19
    '{OP_WR, 2'd1, 32'h8080_80FF, 32'h0,         2'd2, 4'd7},  // R7 control, R2 reserved
    '{OP_RD, 2'd1, 32'h0008_081B, MSK,           2'd0, 4'd7},  // R7 bits 0,1,3,4 only
    '{OP_SN, 2'd0, 32'h0000_003F, 32'h0,         2'd2, 4'd2},  // all pins high
    '{OP_RD, 2'd1, 32'h005F_5F1B, MSK,           2'd2, 4'd2},  // R2 order, R3 flags
    '{OP_WR, 2'd1, 32'h005F_5F1B, 32'h0,         2'd2, 4'd4},  // R4 write back read value
    '{OP_RD, 2'd1, 32'h0000_5F1B, MSK,           2'd2, 4'd4},  // R4 all acknowledged
    '{OP_WR, 2'd0, 32'h0000_0001, 32'h0,         2'd2, 4'd9},  // R9 run
    '{OP_RD, 2'd0, 32'h0000_0001, 32'hFFFF_FFFF, 2'd2, 4'd9},  // R9 run reads back
    '{OP_WR, 2'd0, 32'hFFFF_FFFC, 32'h0,         2'd2, 4'd9},  // R9 stop, other bits 0/ignored
    '{OP_RD, 2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 2'd2, 4'd9},  // R9 stopped
    '{OP_WR, 2'd0, 32'h0000_0001, 32'h0,         2'd2, 4'd9}   // R9 run again
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  line_det = '0;
  logic        pulse_det = 1'b0;
  logic        vbus_dischg_o, vbus_chg_o, term_o, pulse_drv_o, run_o, irq_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otg_event_csr #(.TICK_CYCLES(TICK), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_det(line_det),
    .pulse_det(pulse_det), .vbus_dischg_o(vbus_dischg_o), .vbus_chg_o(vbus_chg_o),
    .term_o(term_o), .pulse_drv_o(pulse_drv_o), .run_o(run_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_sense(input logic [5:0] s);
    @(negedge clk);
    line_det = s[4:0]; pulse_det = s[5];
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 port state after reset
    check({irq_o, run_o, vbus_dischg_o, vbus_chg_o, term_o, pulse_drv_o} == 6'b0, "R1 ports",
          {26'b0, irq_o, run_o, vbus_dischg_o, vbus_chg_o, term_o, pulse_drv_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        OP_WR: bus_write(v.addr, v.data);
        OP_SN: set_sense(v.data[5:0]);
        default: begin
          bus_read(v.addr, rd);
          n_chk++;
          if ((rd & v.mask) != (v.data & v.mask)) begin
            n_bad++;
            $display("FAIL R%0d vector %0d: actual %h expected %h", v.req, i, rd & v.mask,
                     v.data & v.mask);
          end
          if (v.irq != 2'd2) begin
            n_chk++;
            if (irq_o != v.irq[0]) begin
              n_bad++;
              $display("FAIL R%0d vector %0d irq: actual %h expected %h", v.req, i, irq_o, v.irq[0]);
            end
          end
        end
      endcase
    end

    // R7 and R9 at the ports
    #1;
    check({pulse_drv_o, term_o, vbus_chg_o, vbus_dischg_o} == 4'b1111, "R7 control outputs",
          {28'b0, pulse_drv_o, term_o, vbus_chg_o, vbus_dischg_o}, 32'hF);
    check(run_o == 1'b1, "R9 run_o", {31'b0, run_o}, 32'h1);

    // R8: toggle inverts every TICK cycles and sets flag 21; R6 enabled tick raises irq
    begin
      logic [31:0] a0, a1;
      bus_read(2'd1, a0);
      repeat (TICK - 1) @(posedge clk);
      bus_read(2'd1, a1);
      check(a0[13] != a1[13], "R8 toggle period", {31'b0, a1[13]}, {31'b0, ~a0[13]});
      check(a1[21] == 1'b1, "R8 toggle flag", {31'b0, a1[21]}, 32'h1);
      bus_write(2'd1, 32'h2000_001B);
      repeat (3) @(posedge clk);
      #1;
      check(irq_o == 1'b1, "R6 R8 tick irq", {31'b0, irq_o}, 32'h1);
      bus_write(2'd1, 32'h0000_001B);
    end

    // R10: reset bit reads 1 for exactly RSTC cycles, then defaults
    begin
      int ones;
      ones = 0;
      bus_write(2'd0, 32'h0000_0002);
      for (int k = 0; k < 2 * RSTC; k++) begin
        bus_read(2'd0, rd);
        if (rd[1]) ones++;
      end
      check(ones == RSTC, "R10 busy length", ones, RSTC);
      bus_read(2'd1, rd);
      check((rd & MSK) == 32'h0000_5F00, "R10 status defaults", rd & MSK, 32'h0000_5F00);
      bus_read(2'd0, rd);
      check(rd == 32'h0, "R10 command defaults", rd, 32'h0);
      check({run_o, pulse_drv_o, term_o, vbus_chg_o, vbus_dischg_o} == 5'b0, "R10 outputs",
            {27'b0, run_o, pulse_drv_o, term_o, vbus_chg_o, vbus_dischg_o}, 32'h0);
    end

    // R11: writes during the soft reset are dropped
    bus_write(2'd0, 32'h0000_0003);
    bus_write(2'd1, 32'h7F00_001B);
    bus_write(2'd0, 32'h0000_0001);
    repeat (RSTC + 4) @(posedge clk);
    bus_read(2'd1, rd);
    check((rd & MSK) == 32'h0000_5F00, "R11 status write ignored", rd & MSK, 32'h0000_5F00);
    bus_read(2'd0, rd);
    check(rd == 32'h0, "R11 command write ignored", rd, 32'h0);
    check(run_o == 1'b0, "R11 run_o", {31'b0, run_o}, 32'h0);

    // R5: edge of source 0 and its acknowledge land on the same edge
    @(negedge clk);
    line_det = 5'b11110;
    @(posedge clk);
    @(posedge clk);
    bus_write(2'd1, 32'h0001_0000);
    bus_read(2'd1, rd);
    check(rd[16] == 1'b1, "R5 set beats clear", {31'b0, rd[16]}, 32'h1);
    bus_write(2'd1, 32'h0001_0000);
    bus_read(2'd1, rd);
    check(rd[16] == 1'b0, "R4 lone acknowledge", {31'b0, rd[16]}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule